// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block holds the coherence state of one line of a write-back cache that sits on a shared snooping bus. Each cycle it takes at most one request from the processor side (read, write or replace) and at most one transaction observed on the bus from another cache. It returns three things: the bus transaction this cache must issue, a flag saying that this cache supplies the data by cache-to-cache intervention, and the state the line takes after the clock edge.

There are six states. The usual clean/owned and exclusive/shared pairs are joined by a clean owned-shared state. A clean-exclusive line that sees another cache read it does not give up ownership. It moves to clean owned-shared and keeps answering later reads by intervention, even though memory is also up to date. Owned-shared can be entered only from owned-exclusive, and clean owned-shared only from clean-exclusive. The "other copy exists" indication from the bus is used only to pick the state after a read miss. It never changes the transaction that is issued.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset the line is Invalid (`line_state` 0), `bus_req` is 0 (none) and `cci` is 0. State codes: I=0, CE=1, OE=2, CS=3, OS=4, COS=5.
- R2: A CPU read (`cpu_req` 1) in I issues a bus read (`bus_req` 1). The next state is CE when `other_cached` is 0 and CS when it is 1. A read in any other state issues nothing and keeps the state.
- R3: A CPU write (`cpu_req` 2) always leads to OE. From I it issues a read-for-ownership (`bus_req` 2). From CS, OS or COS it issues an invalidate (`bus_req` 3). From CE or OE it issues nothing.
- R4: A replace (`cpu_req` 3) leads to I. It issues a write-back (`bus_req` 4) only from OE or OS. From any other state it issues nothing.
- R5: A snooped read (`snoop_req` 1) sets `cci` and moves CE to COS and OE to OS. In OS or COS it sets `cci` and keeps the state. In I or CS it keeps the state and `cci` stays 0.
- R6: A snooped read-for-ownership (`snoop_req` 2) moves any state to I. `cci` is set in the same cycle exactly when the line was CE, OE, OS or COS.
- R7: A snooped invalidate (`snoop_req` 3) or snooped write-invalidate (`snoop_req` 5) moves any state to I with `cci` at 0.
- R8: A snooped write-back (`snoop_req` 4) has no effect: the state is kept and `cci` stays 0.
- R9: `cci` is 1 only while the line is in an owner state (CE, OE, OS, COS) and a snooped read or read-for-ownership is present.
- R10: OS is entered only from OE, and COS is entered only from CE.
- R11: When a snooped transaction other than write-back arrives in the same cycle as a CPU request, the snoop is handled, the CPU request is ignored and `bus_req` is 0.
- R12: `other_cached` never changes `bus_req`. It only selects the next state of a read miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 2 | 0 idle, 1 read, 2 write, 3 replace |
| snoop_req | input | 3 | Snooped: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back, 5 write-invalidate |
| other_cached | input | 1 | Another cache holds the line; valid with this cycle's bus transaction |
| bus_req | output | 3 | Issued: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| cci | output | 1 | This cache supplies the data by intervention |
| line_state | output | 3 | Registered line state |

## Verification
An internal state that is wrong but still legal looks correct until the next request that tells the states apart. A clean owned-shared line mistaken for clean-shared shows up at the next snooped read, as a missing `cci` in that same cycle. Owned and clean states can be mixed up unnoticed until a replace, when the write-back appears or does not. The stimulus therefore follows every state change with a request that tells the expected state apart from its neighbours. A reference model compares `bus_req` and `cci` before every edge and `line_state` after it.

// File: rtl/coh_pkg.sv
// Shared types for the line coherence controller.
// Assumes one line, one request per side per cycle.
package coh_pkg;
    localparam int ST_W  = 3;
    localparam int CPU_W = 2;
    localparam int BUS_W = 3;

    typedef enum logic [ST_W-1:0] {
        L_I = 3'd0, L_CE = 3'd1, L_OE = 3'd2, L_CS = 3'd3, L_OS = 3'd4, L_COS = 3'd5
    } line_t;

    typedef enum logic [CPU_W-1:0] {
        C_IDLE = 2'd0, C_READ = 2'd1, C_WRITE = 2'd2, C_REPL = 2'd3
    } cpu_t;

    typedef enum logic [BUS_W-1:0] {
        B_NONE = 3'd0, B_CR = 3'd1, B_CRI = 3'd2, B_CI = 3'd3, B_WR = 3'd4, B_CWI = 3'd5
    } bus_t;

    // Owner states answer reads by intervention.
    function automatic logic is_owner(line_t s);
        return (s == L_CE) || (s == L_OE) || (s == L_OS) || (s == L_COS);
    endfunction
endpackage

// File: rtl/snoop_resp.sv
// Response of a line to a transaction observed on the bus.
// Assumes the bus never shows this cache its own transaction.
module snoop_resp
    import coh_pkg::*;
(
    input  line_t cur,
    input  bus_t  sop,
    output logic  act,
    output line_t nxt,
    output logic  cci
);
    // Decide next state and intervention for a snooped transaction.
    always_comb begin
        act = 1'b0;
        nxt = cur;
        cci = 1'b0;
        unique case (sop)
            B_CR: begin
                act = 1'b1;
                cci = is_owner(cur);
                if (cur == L_CE)      nxt = L_COS;
                else if (cur == L_OE) nxt = L_OS;
            end
            B_CRI: begin
                act = 1'b1;
                cci = is_owner(cur);
                nxt = L_I;
            end
            B_CI, B_CWI: begin
                act = 1'b1;
                nxt = L_I;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu_resp.sv
// Response of a line to a processor request.
// The issued transaction depends only on state and request; the other-copy
// flag only picks the state after a read miss.
module cpu_resp
    import coh_pkg::*;
(
    input  line_t cur,
    input  cpu_t  op,
    input  logic  shared_in,
    output line_t nxt,
    output bus_t  bus
);
    // Decide issued transaction and next state for a CPU request.
    always_comb begin
        nxt = cur;
        bus = B_NONE;
        unique case (op)
            C_READ: begin
                if (cur == L_I) begin
                    bus = B_CR;
                    nxt = shared_in ? L_CS : L_CE;
                end
            end
            C_WRITE: begin
                nxt = L_OE;
                if (cur == L_I)                                        bus = B_CRI;
                else if (cur == L_CS || cur == L_OS || cur == L_COS)  bus = B_CI;
            end
            C_REPL: begin
                nxt = L_I;
                if (cur == L_OE || cur == L_OS) bus = B_WR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/snoop_line_ctrl.sv
// Coherence state of one write-back cache line on a snooping bus.
// A snoop that needs action takes priority; a CPU request in the same
// cycle is dropped and must be presented again.
module snoop_line_ctrl
    import coh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CPU_W-1:0] cpu_req,
    input  logic [BUS_W-1:0] snoop_req,
    input  logic             other_cached,
    output logic [BUS_W-1:0] bus_req,
    output logic             cci,
    output logic [ST_W-1:0]  line_state
);
    line_t st_q, st_d, sn_nxt, cp_nxt;
    bus_t  cp_bus;
    logic  sn_act, sn_cci;

    snoop_resp u_snoop (
        .cur (st_q),
        .sop (bus_t'(snoop_req)),
        .act (sn_act),
        .nxt (sn_nxt),
        .cci (sn_cci)
    );

    cpu_resp u_cpu (
        .cur       (st_q),
        .op        (cpu_t'(cpu_req)),
        .shared_in (other_cached),
        .nxt       (cp_nxt),
        .bus       (cp_bus)
    );

    // Select snoop or CPU outcome.
    always_comb begin
        st_d    = sn_act ? sn_nxt : cp_nxt;
        bus_req = sn_act ? B_NONE : cp_bus;
        cci     = sn_cci;
    end

    // Hold the line state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= L_I;
        else        st_q <= st_d;
    end

    assign line_state = st_q;
endmodule

// File: rtl/snoop_line_ctrl_chk.sv
// Protocol checker for snoop_line_ctrl, attached by bind.
module snoop_line_ctrl_chk
    import coh_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CPU_W-1:0] cpu_req,
    input logic [BUS_W-1:0] snoop_req,
    input logic [BUS_W-1:0] bus_req,
    input logic             cci,
    input logic [ST_W-1:0]  line_state
);
    // R9
    cci_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cci |-> ((line_state == L_CE || line_state == L_OE || line_state == L_OS ||
                  line_state == L_COS) && (snoop_req == B_CR || snoop_req == B_CRI)));

    // R10
    os_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state != L_OS && line_state != L_OE) |=> line_state != L_OS);

    // R10
    cos_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state != L_COS && line_state != L_CE) |=> line_state != L_COS);

    // R8
    wb_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_req == B_WR && cpu_req == C_IDLE) |=> $stable(line_state));

    // R7
    inval_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_req == B_CI || snoop_req == B_CWI) |-> !cci ##1 line_state == L_I);

    // R11
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_req inside {B_CR, B_CRI, B_CI, B_CWI}) |-> bus_req == B_NONE);

    // R4
    wb_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_req inside {B_NONE, B_WR} && cpu_req == C_REPL &&
         (line_state == L_OE || line_state == L_OS)) |-> bus_req == B_WR);
endmodule

bind snoop_line_ctrl snoop_line_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .snoop_req  (snoop_req),
    .bus_req    (bus_req),
    .cci        (cci),
    .line_state (line_state)
);

// File: tb/snoop_line_ctrl_tb_top.sv
module snoop_line_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_req = 2'd0;
    logic [2:0] snoop_req = 3'd0;
    logic       other_cached = 1'b0;
    logic [2:0] bus_req;
    logic       cci;
    logic [2:0] line_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int m_st = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    snoop_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .snoop_req(snoop_req),
        .other_cached(other_cached), .bus_req(bus_req), .cci(cci), .line_state(line_state)
    );

    // Reference: states 0 I,1 CE,2 OE,3 CS,4 OS,5 COS.
    function automatic void ref_step(input int s, input int c, input int sn, input bit k,
                                     output int ns, output int b, output bit x);
        bit own = (s == 1 || s == 2 || s == 4 || s == 5);
        ns = s; b = 0; x = 0;
        if (sn == 1) begin
            x = own;
            ns = (s == 1) ? 5 : (s == 2) ? 4 : s;
        end else if (sn == 2) begin
            x = own; ns = 0;
        end else if (sn == 3 || sn == 5) begin
            ns = 0;
        end else if (c == 1) begin
            if (s == 0) begin b = 1; ns = k ? 3 : 1; end
        end else if (c == 2) begin
            ns = 2;
            if (s == 0) b = 2;
            else if (s == 3 || s == 4 || s == 5) b = 3;
        end else if (c == 3) begin
            ns = 0;
            if (s == 2 || s == 4) b = 4;
        end
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input string req, input int c, input int sn, input bit k);
        int ns, b;
        bit x;
        @(negedge clk);
        cpu_req = c[1:0]; snoop_req = sn[2:0]; other_cached = k;
        ref_step(m_st, c, sn, k, ns, b, x);
        #1;
        chk({req, " bus_req"}, int'(bus_req), b);
        chk({req, " cci"}, int'(cci), int'(x));
        @(posedge clk);
        #1;
        chk({req, " line_state"}, int'(line_state), ns);
        m_st = ns;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", int'(line_state), 0);
        chk("R1 reset bus", int'(bus_req), 0);
        chk("R1 reset cci", int'(cci), 0);
        @(negedge clk); rst_n = 1'b1;
        step("R2 read miss alone", 1, 0, 0);     // -> CE
        step("R2 read hit CE", 1, 0, 1);
        step("R8 wb snoop CE", 0, 4, 0);
        step("R5 snoop read CE", 0, 1, 0);       // -> COS
        step("R5 snoop read COS", 0, 1, 0);
        step("R12 read hit COS", 1, 0, 1);
        step("R3 write COS", 2, 0, 0);           // -> OE
        step("R8 wb snoop OE", 0, 4, 0);
        step("R5 snoop read OE", 0, 1, 0);       // -> OS
        step("R5 snoop read OS", 0, 1, 0);
        step("R4 replace OS", 3, 0, 0);          // -> I
        step("R5 snoop read I", 0, 1, 0);
        step("R2 read miss shared", 1, 0, 1);    // -> CS
        step("R5 snoop read CS", 0, 1, 0);
        step("R3 write CS", 2, 0, 1);            // -> OE
        step("R4 replace OE", 3, 0, 0);          // -> I
        step("R3 write miss", 2, 0, 1);          // -> OE
        step("R6 snoop rfo OE", 0, 2, 0);        // -> I
        step("R2 read miss", 1, 0, 0);           // -> CE
        step("R3 write CE", 2, 0, 0);            // silent -> OE
        step("R7 snoop cwi OE", 0, 5, 0);        // -> I
        step("R2 read miss", 1, 0, 0);           // CE
        step("R4 replace CE", 3, 0, 0);          // silent -> I
        step("R2 read miss", 1, 0, 1);           // CS
        step("R6 snoop rfo CS", 0, 2, 0);
        step("R2 read miss", 1, 0, 0);           // CE
        step("R11 snoop vs write", 2, 1, 0);     // -> COS, write dropped
        step("R7 snoop ci COS", 0, 3, 0);        // -> I
        step("R2 read miss", 1, 0, 0);           // CE
        step("R5 snoop read CE", 0, 1, 0);       // COS
        step("R6 snoop rfo COS", 0, 2, 0);       // I
        step("R3 write miss", 2, 0, 0);          // OE
        step("R5 snoop read OE", 0, 1, 0);       // OS
        step("R3 write OS", 2, 0, 0);            // OE
        step("R11 snoop vs replace", 3, 3, 0);   // I, no WR
        step("R12 read miss flag low", 1, 0, 0);
        step("R4 replace CE", 3, 0, 1);
        step("R12 read miss flag high", 1, 0, 1);
        step("R8 wb snoop CS", 0, 4, 1);
        step("R9 idle", 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule